// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Unit

This block gives a host processor three 8-bit parallel ports, called A, B and C, behind a small register interface. Port C is handled as two 4-bit halves. The upper half is bits 7..4 and the lower half is bits 3..0, and each half has its own direction. A control register sets the direction of each port or half. It also stores mode fields for two port groups: group A is port A with upper C, and group B is port B with lower C. Only simple unstrobed input and output is carried out. The mode fields are accepted, stored and read back.

The host uses chip select, active-low read and write strobes, a 2-bit register address and a split data bus. Bit 7 of a value written to the control address decides how the write is decoded. When it is 1, the write replaces the whole configuration. When it is 0, the write sets or clears one bit of the port C output latch and leaves the configuration alone. Every clock edge with chip select and a strobe both low counts as one access. Read data comes back from a register one cycle later, together with a data-valid enable.

Each port pin has separate input, output and output-enable vectors, so the block needs no internal tri-state buffers.

Top module: `pio3_top`

## Requirements
- R1: While `rst` is high, all output latches clear to 0 and every port enable goes low. The stored control word becomes 0x9B, which means all ports are inputs in mode 0. `dout_oe` is low.
- R2: While `cs_n` is high, a write strobe changes no latch and no configuration, and a read strobe leaves `dout_oe` low.
- R3: An edge with `cs_n` = 0 and `wr_n` = 0 writes `din` to the register picked by `addr`: 00 is port A, 01 is port B, 10 is port C (all 8 bits) and 11 is control. The written latch appears on its `*_out` pins after that edge, and no other port latch changes.
- R4: A control write with bit 7 = 1 sets the port directions. Bit 4 controls port A, bit 3 upper C, bit 1 port B and bit 0 lower C. A 1 makes that port an input (its enables low) and a 0 makes it an output (all of its enables high).
- R5: A configuration write clears every output latch to 0. All 8 bits of the word, including the group A mode in bits 6:5 and the group B mode in bit 2, are stored and returned by a read of address 11.
- R6: A control write with bit 7 = 0 loads bit 0 into port C latch bit number bits 3:1. Bits 6:4 are ignored. The stored configuration, the other port C latch bits and ports A and B stay unchanged.
- R7: An edge with `cs_n` = 0, `rd_n` = 0 and `wr_n` = 1 loads `dout` and sets `dout_oe` for the next cycle only. Ports A and B return their latch when they are outputs and the sampled pins when they are inputs.
- R8: A read of port C returns, for each half on its own, the latch when that half is an output and the pins when it is an input.
- R9: When both strobes are low with `cs_n` low, the write takes place and the read does not, so `dout_oe` stays low.
- R10: Writing 0x8A makes port A and lower C outputs and port B and upper C inputs. A following write of 0x0B drives port C bit 5 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, registered |
| dout_oe | output | 1 | High in the cycle after an accepted read |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pin drive enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pin drive enables, upper and lower halves separate |

## Verification
The bench sweeps all 16 direction combinations, each with changing mode bits, and loads the latches before every sweep step. A design that kept old latch values, dropped a mode bit or swapped a direction bit would show a wrong enable, a wrong pin value or a wrong read-back word. It then sets and clears every port C bit one at a time, with junk in bits 6:4. A wrong index decode, a command that also rewrites the configuration, or a command that disturbs neighbouring bits would then show up on `pc_out` or on the control read-back. It also reads port C under all four half-direction mixes, and fires strobes with chip select high or with both strobes low. Those cases catch a read mux that picks by port rather than by half, and a host decoder that ignores the select or lets a read win over a write.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;
  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned HW = DW / 2;
  localparam int unsigned IW = $clog2(DW);

  typedef enum logic [AW-1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } reg_sel_e;

  // control word bit positions (decoded by the port logic)
  localparam int unsigned CW_IO    = 7;
  localparam int unsigned CW_A_IN  = 4;
  localparam int unsigned CW_CU_IN = 3;
  localparam int unsigned CW_B_IN  = 1;
  localparam int unsigned CW_CL_IN = 0;

  localparam logic [DW-1:0] CW_RESET = 8'h9B;
endpackage

// File: rtl/pio3_host_decode.sv
module pio3_host_decode
  import pio3_pkg::*;
(
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic [NREG-1:0] wr_sel,
  output logic          rd_req
);
  logic wr_act;

  assign wr_act = !cs_n && !wr_n;
  // a write strobe always wins over a simultaneous read strobe
  assign rd_req = !cs_n && !rd_n && wr_n;

  always_comb begin
    wr_sel = '0;
    if (wr_act) wr_sel[addr] = 1'b1;
  end
endmodule

// File: rtl/pio3_ctrl.sv
module pio3_ctrl
  import pio3_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cfg_q,
  output logic          cfg_load,
  output logic [DW-1:0] bsr_mask,
  output logic          bsr_val,
  output logic          a_in,
  output logic          b_in,
  output logic          cu_in,
  output logic          cl_in
);
  logic [IW-1:0] bsr_idx;

  assign cfg_load = wr_en && wr_data[CW_IO];
  assign bsr_idx  = wr_data[IW:1];
  assign bsr_val  = wr_data[0];

  always_comb begin
    bsr_mask = '0;
    if (wr_en && !wr_data[CW_IO]) bsr_mask[bsr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= CW_RESET;
    else if (cfg_load) cfg_q <= wr_data;
  end

  assign a_in  = cfg_q[CW_A_IN];
  assign b_in  = cfg_q[CW_B_IN];
  assign cu_in = cfg_q[CW_CU_IN];
  assign cl_in = cfg_q[CW_CL_IN];

  assert_bsr_keeps_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[CW_IO]) |=> $stable(cfg_q));

  assert_cfg_stored_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (cfg_q == $past(wr_data)));

  assert_cfg_io_flag_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_q[CW_IO]);
endmodule

// File: rtl/pio3_lane.sv
module pio3_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] bit_we,
  input  logic         bit_val,
  input  logic         is_input,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] rd_val
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lat_q <= '0;
    end else if (wr_en) begin
      lat_q <= wr_data;
    end else begin
      for (int k = 0; k < W; k++) begin
        if (bit_we[k]) lat_q[k] <= bit_val;
      end
    end
  end

  assign oe     = {W{!is_input}};
  assign rd_val = is_input ? pin_in : lat_q;

  assert_cfg_clears_latch_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (lat_q == '0));

  assert_bsr_one_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !wr_en && (|bit_we)) |=> (((lat_q ^ $past(lat_q)) & ~$past(bit_we)) == '0));

  assert_idle_latch_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !wr_en && !(|bit_we)) |=> $stable(lat_q));
endmodule

// File: rtl/pio3_top.sv
module pio3_top
  import pio3_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  logic [NREG-1:0] wr_sel;
  logic            rd_req;
  logic [DW-1:0]   cfg_q;
  logic            cfg_load;
  logic [DW-1:0]   bsr_mask;
  logic            bsr_val;
  logic            a_in, b_in, cu_in, cl_in;
  logic [DW-1:0]   pa_rd, pb_rd, pc_rd;
  logic [DW-1:0]   rd_mux;

  pio3_host_decode u_host (
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .wr_sel (wr_sel),
    .rd_req (rd_req)
  );

  pio3_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_sel[SEL_CTRL]),
    .wr_data  (din),
    .cfg_q    (cfg_q),
    .cfg_load (cfg_load),
    .bsr_mask (bsr_mask),
    .bsr_val  (bsr_val),
    .a_in     (a_in),
    .b_in     (b_in),
    .cu_in    (cu_in),
    .cl_in    (cl_in)
  );

  pio3_lane #(.W(DW)) u_lane_a (
    .clk     (clk),
    .rst     (rst),
    .clr     (cfg_load),
    .wr_en   (wr_sel[SEL_A]),
    .wr_data (din),
    .bit_we  ('0),
    .bit_val (1'b0),
    .is_input(a_in),
    .pin_in  (pa_in),
    .lat_q   (pa_out),
    .oe      (pa_oe),
    .rd_val  (pa_rd)
  );

  pio3_lane #(.W(DW)) u_lane_b (
    .clk     (clk),
    .rst     (rst),
    .clr     (cfg_load),
    .wr_en   (wr_sel[SEL_B]),
    .wr_data (din),
    .bit_we  ('0),
    .bit_val (1'b0),
    .is_input(b_in),
    .pin_in  (pb_in),
    .lat_q   (pb_out),
    .oe      (pb_oe),
    .rd_val  (pb_rd)
  );

  // port C: two independently directed halves, h = 0 lower, h = 1 upper
  for (genvar h = 0; h < 2; h++) begin : g_pc_half
    localparam int unsigned LO = h * HW;
    pio3_lane #(.W(HW)) u_lane_c (
      .clk     (clk),
      .rst     (rst),
      .clr     (cfg_load),
      .wr_en   (wr_sel[SEL_C]),
      .wr_data (din[LO +: HW]),
      .bit_we  (bsr_mask[LO +: HW]),
      .bit_val (bsr_val),
      .is_input((h == 1) ? cu_in : cl_in),
      .pin_in  (pc_in[LO +: HW]),
      .lat_q   (pc_out[LO +: HW]),
      .oe      (pc_oe[LO +: HW]),
      .rd_val  (pc_rd[LO +: HW])
    );
  end

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_A:   rd_mux = pa_rd;
      SEL_B:   rd_mux = pb_rd;
      SEL_C:   rd_mux = pc_rd;
      default: rd_mux = cfg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_req;
      if (rd_req) dout <= rd_mux;
    end
  end

  assert_read_enable_R7: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(!cs_n && !rd_n && wr_n));

  assert_cs_gate_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout_oe && $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n) |=> !dout_oe);

  assert_dir_apply_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (pa_oe == {DW{!$past(din[CW_A_IN])}}) && (pb_oe == {DW{!$past(din[CW_B_IN])}}));
endmodule

// File: tb/pio3_top_tb_top.sv
module pio3_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       dout_oe;

  int checks = 0;
  int errors = 0;

  logic [7:0] cfg_m, la, lb, lc;

  always #4 clk = ~clk;

  pio3_top dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    // model
    case (a)
      2'b00: la = d;
      2'b01: lb = d;
      2'b10: lc = d;
      default: begin
        if (d[7]) begin cfg_m = d; la = 0; lb = 0; lc = 0; end
        else lc[d[3:1]] = d[0];
      end
    endcase
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    v = dout; oe = dout_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'b00: r = cfg_m[4] ? pa_in : la;
      2'b01: r = cfg_m[1] ? pb_in : lb;
      2'b10: r = {cfg_m[3] ? pc_in[7:4] : lc[7:4], cfg_m[0] ? pc_in[3:0] : lc[3:0]};
      default: r = cfg_m;
    endcase
    return r;
  endfunction

  task automatic check_pins(input string tag);
    check({tag, " pa_oe"}, pa_oe, {8{~cfg_m[4]}});
    check({tag, " pb_oe"}, pb_oe, {8{~cfg_m[1]}});
    check({tag, " pc_oe"}, pc_oe, {{4{~cfg_m[3]}}, {4{~cfg_m[0]}}});
    check({tag, " pa_out"}, pa_out, la);
    check({tag, " pb_out"}, pb_out, lb);
    check({tag, " pc_out"}, pc_out, lc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       oe;
    cfg_m = 8'h9B; la = 0; lb = 0; lc = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_pins("R1 reset");
    check("R1 dout_oe", dout_oe, 1'b0);
    bus_rd(2'b11, v, oe);
    check("R1 ctrl readback", v, 8'h9B);
    check("R7 read enable", oe, 1'b1);

    // R10 worked examples
    bus_wr(2'b11, 8'h8A);
    check("R10 pa_oe after 0x8A", pa_oe, 8'hFF);
    check("R10 pb_oe after 0x8A", pb_oe, 8'h00);
    check("R10 pc_oe after 0x8A", pc_oe, 8'h0F);
    bus_wr(2'b11, 8'h0B);
    check("R10 pc bit5 after 0x0B", pc_out, 8'h20);
    bus_rd(2'b11, v, oe);
    check("R6 cfg kept after bsr", v, 8'h8A);

    // R4/R5 sweep over all direction combinations
    for (int i = 0; i < 16; i++) begin
      logic [7:0] w;
      w = 8'h80;
      w[0] = i[0]; w[1] = i[1]; w[3] = i[2]; w[4] = i[3];
      w[2] = i[0] ^ i[3];
      w[6:5] = i[2:1];
      bus_wr(2'b00, 8'h5A);
      bus_wr(2'b01, 8'hA5);
      bus_wr(2'b10, 8'h3C);
      bus_wr(2'b11, w);
      check_pins("R4 R5 sweep");
      bus_rd(2'b11, v, oe);
      check("R5 cfg readback", v, w);
    end

    // R3 writes per address, R7 readback of output latches
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h12);
    check_pins("R3 after write A");
    bus_wr(2'b01, 8'h34);
    check_pins("R3 after write B");
    bus_wr(2'b10, 8'h56);
    check_pins("R3 after write C");
    pa_in = 8'hC3; pb_in = 8'h3C; pc_in = 8'h99;
    for (int a = 0; a < 4; a++) begin
      bus_rd(a[1:0], v, oe);
      check("R7 output readback", v, exp_read(a[1:0]));
      check("R7 oe high", oe, 1'b1);
      @(negedge clk);
      check("R7 oe one cycle", dout_oe, 1'b0);
    end

    // R7 input sampling on A and B
    bus_wr(2'b11, 8'h9B);
    for (int p = 0; p < 4; p++) begin
      pa_in = 8'h11 * p[7:0] + 8'h0F;
      pb_in = ~pa_in;
      bus_rd(2'b00, v, oe);
      check("R7 port A pins", v, pa_in);
      bus_rd(2'b01, v, oe);
      check("R7 port B pins", v, pb_in);
    end

    // R8 port C half mixes
    for (int m = 0; m < 4; m++) begin
      logic [7:0] w;
      w = 8'h80; w[0] = m[0]; w[3] = m[1];
      bus_wr(2'b11, w);
      bus_wr(2'b10, 8'hA5);
      pc_in = 8'h3C;
      check_pins("R8 mix pins");
      bus_rd(2'b10, v, oe);
      check("R8 port C mixed read", v, exp_read(2'b10));
    end

    // R6 bit set/reset sweep
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h77);
    bus_wr(2'b01, 8'h88);
    for (int val = 1; val >= 0; val--) begin
      for (int idx = 0; idx < 8; idx++) begin
        logic [7:0] w;
        w = {1'b0, idx[2:0] ^ 3'b101, idx[2:0], val[0]};
        bus_wr(2'b11, w);
        check_pins("R6 bsr");
      end
    end
    bus_wr(2'b11, 8'h7F);
    bus_wr(2'b11, 8'h05);
    check_pins("R6 bsr odd bits");
    bus_rd(2'b11, v, oe);
    check("R6 cfg unchanged", v, 8'h80);

    // R2 chip select gating
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'b00; din = 8'hFF;
    @(negedge clk);
    addr = 2'b11; din = 8'h9B;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    check("R2 no read when deselected", dout_oe, 1'b0);
    rd_n = 1'b1;
    check_pins("R2 ignored writes");

    // R9 write wins over read
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; addr = 2'b00; din = 8'h99;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    la = 8'h99;
    check("R9 read suppressed", dout_oe, 1'b0);
    check("R9 write applied", pa_out, 8'h99);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule